// File: doc/BRIEF.md
# Mixed-Width Register Access Splitter

This block sits between a processor load/store port and a 512-byte peripheral register window. The processor issues byte, halfword or word accesses. Each register in the window has a native width of one, two or four bytes. A fixed width table, indexed by 4-byte group, gives the native width of every register and also marks groups where no register is implemented. When the processor access is wider than the register, the adapter breaks it into a run of native-width sub-accesses at rising addresses. When the access is narrower, the adapter performs one native-width read and selects the addressed lane. For a narrow write, it follows that read with a write of the merged value (read-modify-write). All lane placement is big-endian: the lowest byte address maps to the most significant byte.

On the downstream side there is a single request/acknowledge port that carries a size code. The adapter holds each sub-access on that port until it is acknowledged, then issues the next one. It reports completion to the processor with a one-cycle done pulse, and only after the last sub-access has been acknowledged. Accesses outside the window, or into an unimplemented group, complete immediately. They raise an error flag and return zero.

Top module: `regwin_width_adapter`

## Requirements
- R1: Size code 0 means byte, 1 means halfword and 2 means word, on both ports. The native width is taken from offset bits [8:2] as follows:
  - bytes 0x000-0x03F and 0x180-0x1DF are byte registers;
  - 0x040-0x07F and 0x100-0x13F are halfword registers;
  - 0x080-0x0BF and 0x140-0x17F are word registers;
  - 0x0C0-0x0FF and 0x1E0-0x1FF are unimplemented.

  Every downstream request uses the native size of its group, at an address aligned to that size.
- R2: An access whose size equals the native width produces exactly one downstream access, at the same offset and with the same direction.
- R3: An access wider than the native width produces (access bytes / native bytes) downstream accesses of native size, at ascending offsets. The lowest offset carries the most significant part of the data.
- R4: A read narrower than the native width produces one native read at the offset rounded down to native alignment. The result is the big-endian lane of the offset, right-aligned.
- R5: A write narrower than the native width produces a native read and then a native write to the same offset. Only the addressed bytes change.
- R6: An offset of 0x200 or above completes with the error flag set and read data zero, and issues no downstream access.
- R7: An access to an unimplemented group, or one using size code 3, behaves exactly like R6.
- R8: A downstream request holds its address, size, direction and data until it is acknowledged. Done pulses for exactly one cycle, after the last acknowledge.
- R9: After reset no downstream request, done or error is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle access request, accepted while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access size code |
| cpu_addr | input | ADDR_W | Byte offset of the access |
| cpu_wdata | input | 32 | Write data, right-aligned to the access size |
| cpu_done | output | 1 | Completion pulse |
| cpu_err | output | 1 | Error flag, valid with done |
| cpu_rdata | output | 32 | Read data, right-aligned, valid with done |
| periph_req | output | 1 | Downstream sub-access request |
| periph_we | output | 1 | Downstream direction |
| periph_size | output | 2 | Downstream size code |
| periph_addr | output | 9 | Downstream byte offset |
| periph_wdata | output | 32 | Downstream write data, right-aligned |
| periph_ack | input | 1 | Downstream acknowledge, one cycle |
| periph_rdata | input | 32 | Downstream read data, right-aligned, valid with ack |

## Verification
The properties assume three things about the processor side:
- a request is raised only while the adapter is idle, that is, never between acceptance and done;
- every access offset is a multiple of its own size;
- the acknowledge is a single-cycle pulse given only while a request is pending.

The bench issues each access only after the previous done has been seen, and uses only naturally aligned offsets. Its peripheral model pulses acknowledge once per request after a varying stall of zero to two cycles.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int WIN_BYTES = 512;
    localparam int OFS_W     = $clog2(WIN_BYTES);
    localparam int GROUPS    = WIN_BYTES / 4;
    localparam int GRP_W     = $clog2(GROUPS);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    typedef struct packed {
        logic             fault;
        logic             widen;
        logic             rmw;
        logic [2:0]       count;
        logic [OFS_W-1:0] base;
    } plan_t;

    function automatic logic [2:0] nbytes(input size_e s);
        case (s)
            SZ_BYTE: nbytes = 3'd1;
            SZ_HALF: nbytes = 3'd2;
            SZ_WORD: nbytes = 3'd4;
            default: nbytes = 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input size_e s);
        case (s)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            SZ_WORD: size_mask = 32'hFFFF_FFFF;
            default: size_mask = 32'h0;
        endcase
    endfunction

    // Native register width of a 4-byte group (group index = offset[8:2]).
    function automatic size_e group_size(input logic [GRP_W-1:0] g);
        case (g[GRP_W-1:GRP_W-3])
            3'd0:    group_size = SZ_BYTE;
            3'd1:    group_size = SZ_HALF;
            3'd2:    group_size = SZ_WORD;
            3'd3:    group_size = SZ_NONE;
            3'd4:    group_size = SZ_HALF;
            3'd5:    group_size = SZ_WORD;
            3'd6:    group_size = SZ_BYTE;
            default: group_size = g[GRP_W-4] ? SZ_NONE : SZ_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/regwin_width_rom.sv
module regwin_width_rom
    import regwin_pkg::*;
(
    input  logic [GRP_W-1:0] grp,
    output size_e            native
);
    size_e table_q [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_tbl
        assign table_q[g] = group_size(GRP_W'(g));
    end

    assign native = table_q[grp];
endmodule

// File: rtl/regwin_planner.sv
module regwin_planner
    import regwin_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  size_e             req_size,
    input  logic              we,
    input  size_e             native,
    output plan_t             plan
);
    logic             in_win;
    logic [2:0]       nb_nat;
    logic [OFS_W-1:0] align_mask;
    logic [OFS_W-1:0] ofs;

    assign in_win     = ({1'b0, addr} < (ADDR_W+1)'(WIN_BYTES));
    assign nb_nat     = nbytes(native);
    assign align_mask = ~OFS_W'(nb_nat - 3'd1);
    assign ofs        = addr[OFS_W-1:0];

    always_comb begin
        plan.fault = !in_win || (native == SZ_NONE) || (req_size == SZ_NONE);
        plan.widen = (req_size < native);
        plan.rmw   = plan.widen && we;
        if (req_size > native)
            plan.count = 3'd1 << (req_size - native);
        else
            plan.count = 3'd1;
        plan.base = plan.widen ? (ofs & align_mask) : ofs;
    end
endmodule

// File: rtl/regwin_lanes.sv
module regwin_lanes
    import regwin_pkg::*;
(
    input  size_e       native,
    input  size_e       req_size,
    input  logic [1:0]  lane,
    input  logic [31:0] rd_word,
    input  logic [31:0] new_data,
    output logic [31:0] picked,
    output logic [31:0] merged
);
    logic [2:0]  gap;
    logic [5:0]  sh;
    logic [31:0] m;

    // Big-endian: byte at lane 0 is the most significant of the register.
    assign gap    = nbytes(native) - nbytes(req_size) - {1'b0, lane};
    assign sh     = {gap, 3'b000};
    assign m      = size_mask(req_size);
    assign picked = (rd_word >> sh) & m;
    assign merged = (rd_word & ~(m << sh)) | ((new_data & m) << sh);
endmodule

// File: rtl/regwin_width_adapter.sv
module regwin_width_adapter
    import regwin_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_done,
    output logic              cpu_err,
    output logic [31:0]       cpu_rdata,
    output logic              periph_req,
    output logic              periph_we,
    output logic [1:0]        periph_size,
    output logic [OFS_W-1:0]  periph_addr,
    output logic [31:0]       periph_wdata,
    input  logic              periph_ack,
    input  logic [31:0]       periph_rdata
);
    size_e  req_sz;
    size_e  nat_sz;
    plan_t  plan;

    assign req_sz = size_e'(cpu_size);

    regwin_width_rom u_rom (
        .grp    (cpu_addr[GRP_W+1:2]),
        .native (nat_sz)
    );

    regwin_planner #(.ADDR_W(ADDR_W)) u_plan (
        .addr     (cpu_addr),
        .req_size (req_sz),
        .we       (cpu_we),
        .native   (nat_sz),
        .plan     (plan)
    );

    state_e      st;
    size_e       cur_nat;
    size_e       cur_req;
    logic [1:0]  cur_lane;
    logic        cur_widen;
    logic        cur_rmw;
    logic        cur_we;
    logic [2:0]  remaining;
    logic [31:0] wshift;
    logic [31:0] acc;
    logic [31:0] hold_wdata;
    logic [31:0] result;
    logic        err_r;
    logic        preq;
    logic        pwe;
    size_e       psize;
    logic [OFS_W-1:0] paddr;
    logic [31:0] pwdata;

    logic [31:0] picked;
    logic [31:0] merged;

    regwin_lanes u_lanes (
        .native   (cur_nat),
        .req_size (cur_req),
        .lane     (cur_lane),
        .rd_word  (periph_rdata),
        .new_data (hold_wdata),
        .picked   (picked),
        .merged   (merged)
    );

    // Accept-time data alignment: left-justify write data, take first chunk.
    logic [2:0]  nb_req;
    logic [2:0]  nb_nat;
    logic [31:0] wsh0;
    logic [31:0] chunk0;
    logic [1:0]  lane0;

    assign nb_req = nbytes(req_sz);
    assign nb_nat = nbytes(nat_sz);
    assign wsh0   = cpu_wdata << (6'd32 - {nb_req, 3'b000});
    assign chunk0 = wsh0 >> (6'd32 - {nb_nat, 3'b000});
    assign lane0  = cpu_addr[1:0] & 2'(nb_nat - 3'd1);

    // Per-sub-access stepping in a split.
    logic [2:0]  nb_cur;
    logic [5:0]  step_bits;
    logic [31:0] acc_next;
    logic [31:0] wshift_next;
    logic [31:0] chunk_next;

    assign nb_cur      = nbytes(cur_nat);
    assign step_bits   = {nb_cur, 3'b000};
    assign acc_next    = (acc << step_bits) | (periph_rdata & size_mask(cur_nat));
    assign wshift_next = wshift << step_bits;
    assign chunk_next  = wshift_next >> (6'd32 - step_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cur_nat    <= SZ_BYTE;
            cur_req    <= SZ_BYTE;
            cur_lane   <= 2'd0;
            cur_widen  <= 1'b0;
            cur_rmw    <= 1'b0;
            cur_we     <= 1'b0;
            remaining  <= 3'd0;
            wshift     <= 32'd0;
            acc        <= 32'd0;
            hold_wdata <= 32'd0;
            result     <= 32'd0;
            err_r      <= 1'b0;
            preq       <= 1'b0;
            pwe        <= 1'b0;
            psize      <= SZ_BYTE;
            paddr      <= '0;
            pwdata     <= 32'd0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (cpu_req) begin
                        cur_nat    <= nat_sz;
                        cur_req    <= req_sz;
                        cur_lane   <= lane0;
                        cur_widen  <= plan.widen;
                        cur_rmw    <= plan.rmw;
                        cur_we     <= cpu_we;
                        remaining  <= plan.count;
                        wshift     <= wsh0;
                        acc        <= 32'd0;
                        hold_wdata <= cpu_wdata;
                        result     <= 32'd0;
                        if (plan.fault) begin
                            err_r <= 1'b1;
                            st    <= ST_RESP;
                        end else begin
                            err_r  <= 1'b0;
                            preq   <= 1'b1;
                            pwe    <= cpu_we && !plan.widen;
                            psize  <= nat_sz;
                            paddr  <= plan.base;
                            pwdata <= plan.widen ? 32'd0 : chunk0;
                            st     <= ST_BUSY;
                        end
                    end
                end
                ST_BUSY: begin
                    if (periph_ack) begin
                        if (cur_widen) begin
                            if (cur_rmw && !pwe) begin
                                pwe    <= 1'b1;
                                pwdata <= merged;
                            end else begin
                                preq   <= 1'b0;
                                pwe    <= 1'b0;
                                result <= cur_we ? 32'd0 : picked;
                                st     <= ST_RESP;
                            end
                        end else begin
                            acc <= acc_next;
                            if (remaining == 3'd1) begin
                                preq   <= 1'b0;
                                pwe    <= 1'b0;
                                result <= cur_we ? 32'd0 : acc_next;
                                st     <= ST_RESP;
                            end else begin
                                remaining <= remaining - 3'd1;
                                paddr     <= paddr + OFS_W'(nb_cur);
                                wshift    <= wshift_next;
                                pwdata    <= chunk_next;
                            end
                        end
                    end
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    assign cpu_done     = (st == ST_RESP);
    assign cpu_err      = err_r;
    assign cpu_rdata    = result;
    assign periph_req   = preq;
    assign periph_we    = pwe;
    assign periph_size  = psize;
    assign periph_addr  = paddr;
    assign periph_wdata = pwdata;
endmodule

// File: rtl/regwin_width_adapter_chk.sv
module regwin_width_adapter_chk
    import regwin_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cpu_done,
    input logic             cpu_err,
    input logic [31:0]      cpu_rdata,
    input logic             periph_req,
    input logic             periph_we,
    input logic [1:0]       periph_size,
    input logic [OFS_W-1:0] periph_addr,
    input logic [31:0]      periph_wdata,
    input logic             periph_ack
);
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        periph_req && !periph_ack |=> periph_req && $stable(periph_addr)
            && $stable(periph_size) && $stable(periph_we) && $stable(periph_wdata));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    a_r6_err_zero: assert property (@(posedge clk) disable iff (rst)
        cpu_done && cpu_err |-> cpu_rdata == 32'd0);

    a_r1_native_size: assert property (@(posedge clk) disable iff (rst)
        periph_req |-> size_e'(periph_size) == group_size(periph_addr[GRP_W+1:2]));

    a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
        periph_req |-> (periph_addr & OFS_W'(nbytes(size_e'(periph_size)) - 3'd1)) == '0);

    a_r8_quiet_on_done: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !periph_req);
endmodule

bind regwin_width_adapter regwin_width_adapter_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_done     (cpu_done),
    .cpu_err      (cpu_err),
    .cpu_rdata    (cpu_rdata),
    .periph_req   (periph_req),
    .periph_we    (periph_we),
    .periph_size  (periph_size),
    .periph_addr  (periph_addr),
    .periph_wdata (periph_wdata),
    .periph_ack   (periph_ack)
);

// File: tb/tb_regwin_width_adapter.sv
module tb_regwin_width_adapter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [9:0]  cpu_addr = 10'd0;
    logic [31:0] cpu_wdata = 32'd0;
    logic        cpu_done, cpu_err;
    logic [31:0] cpu_rdata;
    logic        periph_req, periph_we;
    logic [1:0]  periph_size;
    logic [8:0]  periph_addr;
    logic [31:0] periph_wdata;
    logic        periph_ack = 1'b0;
    logic [31:0] periph_rdata = 32'd0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    regwin_width_adapter dut (.*);

    logic [7:0] pmem   [512];
    logic [7:0] shadow [512];
    int exp_addr[$];
    int exp_size[$];
    int exp_we[$];
    int stall_sel = 0;
    int wcnt = 0;

    function automatic int width_of(int a);
        if (a < 'h040) return 1;
        if (a < 'h080) return 2;
        if (a < 'h0C0) return 4;
        if (a < 'h100) return 0;
        if (a < 'h140) return 2;
        if (a < 'h180) return 4;
        if (a < 'h1E0) return 1;
        return 0;
    endfunction

    function automatic int code_of(int w);
        return (w == 1) ? 0 : (w == 2) ? 1 : 2;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Peripheral model: acknowledges after a stall of 0..2 cycles.
    always @(posedge clk) begin
        if (rst) begin
            periph_ack <= 1'b0;
            wcnt = 0;
        end else if (periph_ack) begin
            periph_ack <= 1'b0;
        end else if (periph_req) begin
            if (wcnt >= stall_sel % 3) begin
                automatic int n = 1 << periph_size;
                automatic logic [31:0] v = 0;
                if (exp_addr.size() == 0) begin
                    check(0, "R2", "unexpected downstream access", periph_addr, 0);
                end else begin
                    automatic int ea = exp_addr.pop_front();
                    automatic int es = exp_size.pop_front();
                    automatic int ew = exp_we.pop_front();
                    check(periph_addr == ea && periph_size == es && periph_we == ew,
                          "R3", "sub-access addr/size/we",
                          {periph_addr, 2'b0, periph_size, 3'b0, periph_we},
                          {ea[8:0], 2'b0, es[1:0], 3'b0, ew[0]});
                end
                for (int i = 0; i < n; i++) v = (v << 8) | pmem[periph_addr + i];
                if (periph_we)
                    for (int i = 0; i < n; i++)
                        pmem[periph_addr + i] = periph_wdata[8*(n-1-i) +: 8];
                periph_rdata <= v;
                periph_ack <= 1'b1;
                wcnt = 0;
                stall_sel++;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic access(input int sz, input int a, input bit we,
                          input logic [31:0] wd, input string req);
        automatic int s = 1 << sz;
        automatic int w = (a < 512) ? width_of(a) : 0;
        automatic bit fault = (w == 0);
        automatic logic [31:0] exp_rd = 0;
        automatic int waited = 0;
        if (!fault) begin
            if (s >= w) begin
                for (int k = 0; k < s / w; k++) begin
                    exp_addr.push_back(a + k * w); exp_size.push_back(code_of(w));
                    exp_we.push_back(we);
                end
            end else begin
                automatic int b = a - (a % w);
                exp_addr.push_back(b); exp_size.push_back(code_of(w)); exp_we.push_back(0);
                if (we) begin
                    exp_addr.push_back(b); exp_size.push_back(code_of(w)); exp_we.push_back(1);
                end
            end
            if (we) for (int i = 0; i < s; i++) shadow[a + i] = wd[8*(s-1-i) +: 8];
            else    for (int i = 0; i < s; i++) exp_rd = (exp_rd << 8) | shadow[a + i];
        end
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_size = sz[1:0]; cpu_addr = a[9:0]; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
        while (!cpu_done && waited < 200) begin @(negedge clk); waited++; end
        check(cpu_done, req, "done seen", cpu_done, 1);
        check(cpu_err == fault, req, "error flag", cpu_err, fault);
        check(cpu_rdata == exp_rd, req, "read data", cpu_rdata, exp_rd);
        check(exp_addr.size() == 0, req, "all sub-accesses issued", exp_addr.size(), 0);
        exp_addr.delete(); exp_size.delete(); exp_we.delete();
        @(negedge clk);
        check(!cpu_done, "R8", "done is one cycle", cpu_done, 0);
        if (we || fault) begin
            automatic int bad = 0;
            for (int i = 0; i < 512; i++) if (pmem[i] !== shadow[i]) bad++;
            check(bad == 0, req, "register contents", bad, 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            pmem[i] = 8'((i * 37 + 11) ^ (i >> 3));
            shadow[i] = pmem[i];
        end
        repeat (3) @(negedge clk);
        check(!periph_req && !cpu_done && !cpu_err, "R9", "reset outputs",
              {periph_req, cpu_done, cpu_err}, 0);
        rst = 0;
        // R2 matching sizes
        access(0, 'h005, 0, 0, "R2");
        access(1, 'h042, 0, 0, "R2");
        access(2, 'h084, 0, 0, "R2");
        access(2, 'h150, 1, 32'hCAFE_F00D, "R2");
        // R3 splits
        access(1, 'h010, 0, 0, "R3");
        access(2, 'h020, 0, 0, "R3");
        access(2, 'h104, 0, 0, "R3");
        access(2, 'h024, 1, 32'h1122_3344, "R3");
        access(1, 'h190, 1, 32'h0000_A5B6, "R3");
        access(2, 'h048, 1, 32'hDEAD_BEEF, "R3");
        // R4 narrow reads
        access(0, 'h043, 0, 0, "R4");
        access(0, 'h044, 0, 0, "R4");
        access(0, 'h081, 0, 0, "R4");
        access(0, 'h083, 0, 0, "R4");
        access(1, 'h142, 0, 0, "R4");
        access(1, 'h140, 0, 0, "R4");
        // R5 narrow writes (read-modify-write)
        access(0, 'h05B, 1, 32'h0000_0077, "R5");
        access(0, 'h05C, 1, 32'h0000_0088, "R5");
        access(0, 'h0A2, 1, 32'h0000_0099, "R5");
        access(1, 'h14E, 1, 32'h0000_1357, "R5");
        access(1, 'h14C, 1, 32'h0000_2468, "R5");
        // R6 / R7 faults
        access(0, 'h200, 0, 0, "R6");
        access(2, 'h3FC, 1, 32'hFFFF_FFFF, "R6");
        access(0, 'h0C4, 1, 32'h0000_00AB, "R7");
        access(2, 'h0E0, 0, 0, "R7");
        access(1, 'h1E4, 0, 0, "R7");
        // read back after writes and faults
        access(2, 'h14C, 0, 0, "R5");
        access(2, 'h058, 0, 0, "R5");
        access(2, 'h024, 0, 0, "R3");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule